// File: doc/BRIEF.md
# Linked-List Multi-Queue Buffer Manager

This block keeps many first-in first-out queues of fixed-size buffers. All queues draw on one shared pool of buffers. Each queue has a record that holds its first buffer, its last buffer and the number of buffers it contains. Each buffer has a link entry that names the buffer after it. Buffers that no queue holds are chained on a free list. One link array serves both the free list and every per-flow queue.

A caller sends one command at a time. An enqueue command names a queue. The block takes the first buffer off the free list, returns that buffer's address so the caller can write the packet into it, and attaches the buffer to the end of the named queue. A dequeue command takes the first buffer off the named queue, returns its address, and attaches it to the end of the free list. The block handles only buffer addresses; packet payload lives somewhere else. The queue records and the link entries sit in internal memories. Both memories have synchronous reads, so each update is a read of a record followed by a write of it.

Top module: `qm_buffer_manager`

## Requirements
- R1: After `rst` is released, `cmd_ready` stays low for exactly NUM_BUFS clock edges while the free list is built and the queues are cleared. It then rises, and every queue is empty. `rsp_valid` is low throughout this period.
- R2: After reset the free list chains the buffers in ascending order. Successive enqueues therefore return the addresses 0, 1, 2 and so on.
- R3: `cmd_op` = 0 means enqueue and `cmd_op` = 1 means dequeue. A command is accepted on a clock edge where `cmd_valid` and `cmd_ready` are both high. `cmd_ready` is then low until the response has been issued, so only one command is outstanding at a time.
- R4: `rsp_valid` is a pulse one cycle long. It appears two clock edges after the acceptance edge when the command succeeds, and one edge after it when the command is rejected.
- R5: A successful enqueue returns the buffer at the head of the free list in `rsp_addr`, with `rsp_err` = 0.
- R6: A successful dequeue returns the queue's buffers in the order in which they were enqueued, with `rsp_err` = 0.
- R7: Queues are independent: commands on one queue do not change the order or the contents of any other queue.
- R8: A dequeue from an empty queue responds with `rsp_err` = 1 and `rsp_addr` = 0, and changes no state.
- R9: An enqueue while the free list is empty responds with `rsp_err` = 1 and `rsp_addr` = 0, and changes no state.
- R10: A dequeued buffer goes to the end of the free list. It is handed out again only after every buffer already on the free list, including when the free list was empty before the dequeue.
- R11: A queue that has been drained to empty accepts new buffers and returns them in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | A command is offered |
| cmd_ready | output | 1 | The block can accept a command |
| cmd_op | input | 1 | 0 = enqueue, 1 = dequeue |
| cmd_qid | input | $clog2(NUM_QUEUES) | Target queue |
| rsp_valid | output | 1 | Pulse: the response is valid |
| rsp_addr | output | $clog2(NUM_BUFS) | Buffer allocated or released; 0 on error |
| rsp_err | output | 1 | The command was rejected |

## Verification
The hardest case to reach from the ports is a free list that is fully empty and then refilled. When a buffer is returned to an empty free list, its address becomes both the head and the tail of the free list, and none of the stale link entries may be used. The bench gets there by enqueuing until the pool is used up across several queues. It then makes one more enqueue, which must be rejected. After that it dequeues from different queues and enqueues again. The bench's own list model predicts which addresses come back and in what order. The same sequence also drains a queue to empty and refills it, which checks that a stale head or tail in the queue record is never followed.

// File: rtl/qm_pkg.sv
package qm_pkg;
  typedef enum logic [1:0] {
    ST_INIT  = 2'd0,
    ST_IDLE  = 2'd1,
    ST_FETCH = 2'd2,
    ST_APPLY = 2'd3
  } qm_state_e;

  typedef enum logic {
    OP_ENQ = 1'b0,
    OP_DEQ = 1'b1
  } qm_op_e;
endpackage

// File: rtl/qm_sdp_ram.sv
module qm_sdp_ram #(
  parameter int DEPTH  = 16,
  parameter int ADDR_W = 4,
  parameter int WIDTH  = 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [WIDTH-1:0]  wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [WIDTH-1:0]  rdata
);
  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/qm_free_list.sv
module qm_free_list #(
  parameter int NUM_BUFS = 16,
  parameter int AW       = 4,
  parameter int CW       = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          pop,
  input  logic [AW-1:0] pop_next,
  input  logic          push,
  input  logic [AW-1:0] push_buf,
  output logic [AW-1:0] head,
  output logic [AW-1:0] tail,
  output logic [CW-1:0] cnt
);
  always_ff @(posedge clk) begin
    if (rst) begin
      head <= '0;
      tail <= AW'(NUM_BUFS - 1);
      cnt  <= CW'(NUM_BUFS);
    end else if (pop) begin
      head <= pop_next;
      cnt  <= cnt - CW'(1);
    end else if (push) begin
      if (cnt == '0) head <= push_buf;
      tail <= push_buf;
      cnt  <= cnt + CW'(1);
    end
  end

  // Taking a buffer from an empty pool must have been rejected upstream
  assert_pop_nonempty_R9: assert property (@(posedge clk) disable iff (rst)
    pop |-> cnt != '0);
  // One command at a time: never a pop and a push in the same cycle
  assert_single_update_R3: assert property (@(posedge clk) disable iff (rst)
    !(pop && push));
endmodule

// File: rtl/qm_buffer_manager.sv
module qm_buffer_manager
  import qm_pkg::*;
#(
  parameter int NUM_BUFS   = 16,
  parameter int NUM_QUEUES = 4,
  localparam int AW = (NUM_BUFS > 1) ? $clog2(NUM_BUFS) : 1,
  localparam int QW = (NUM_QUEUES > 1) ? $clog2(NUM_QUEUES) : 1,
  localparam int CW = $clog2(NUM_BUFS + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cmd_valid,
  output logic          cmd_ready,
  input  logic          cmd_op,
  input  logic [QW-1:0] cmd_qid,
  output logic          rsp_valid,
  output logic [AW-1:0] rsp_addr,
  output logic          rsp_err
);
  localparam int DW = 2 * AW + CW;

  qm_state_e     state;
  logic [AW-1:0] init_idx;
  qm_op_e        op_r;
  logic [QW-1:0] qid_r;
  logic [AW-1:0] buf_r;
  logic [AW-1:0] q_head, q_tail;
  logic [CW-1:0] q_cnt;

  logic          d_we;
  logic [QW-1:0] d_waddr;
  logic [DW-1:0] d_wdata, d_rdata;
  logic          l_we;
  logic [AW-1:0] l_waddr, l_wdata, l_raddr, l_rdata;
  logic          f_pop, f_push;
  logic [AW-1:0] f_head, f_tail;
  logic [CW-1:0] f_cnt;

  logic [AW-1:0] rd_head, rd_tail;
  logic [CW-1:0] rd_cnt;
  assign rd_head = d_rdata[DW-1 -: AW];
  assign rd_tail = d_rdata[CW+AW-1 -: AW];
  assign rd_cnt  = d_rdata[CW-1:0];

  assign cmd_ready = (state == ST_IDLE);

  qm_sdp_ram #(.DEPTH(NUM_QUEUES), .ADDR_W(QW), .WIDTH(DW)) i_desc_ram (
    .clk(clk), .we(d_we), .waddr(d_waddr), .wdata(d_wdata),
    .raddr(cmd_qid), .rdata(d_rdata));

  qm_sdp_ram #(.DEPTH(NUM_BUFS), .ADDR_W(AW), .WIDTH(AW)) i_link_ram (
    .clk(clk), .we(l_we), .waddr(l_waddr), .wdata(l_wdata),
    .raddr(l_raddr), .rdata(l_rdata));

  qm_free_list #(.NUM_BUFS(NUM_BUFS), .AW(AW), .CW(CW)) i_free (
    .clk(clk), .rst(rst), .pop(f_pop), .pop_next(l_rdata),
    .push(f_push), .push_buf(buf_r),
    .head(f_head), .tail(f_tail), .cnt(f_cnt));

  always_comb begin
    l_raddr = (op_r == OP_ENQ) ? f_head : rd_head;
    d_we    = 1'b0;
    d_waddr = qid_r;
    d_wdata = '0;
    l_we    = 1'b0;
    l_waddr = '0;
    l_wdata = '0;
    f_pop   = 1'b0;
    f_push  = 1'b0;
    if (state == ST_INIT) begin
      l_we    = 1'b1;
      l_waddr = init_idx;
      l_wdata = init_idx + AW'(1);
      d_we    = (32'(init_idx) < NUM_QUEUES);
      d_waddr = QW'(init_idx);
    end else if (state == ST_APPLY) begin
      d_we = 1'b1;
      if (op_r == OP_ENQ) begin
        f_pop = 1'b1;
        if (q_cnt == '0) begin
          d_wdata = {buf_r, buf_r, CW'(1)};
        end else begin
          l_we    = 1'b1;
          l_waddr = q_tail;
          l_wdata = buf_r;
          d_wdata = {q_head, buf_r, q_cnt + CW'(1)};
        end
      end else begin
        f_push  = 1'b1;
        d_wdata = {l_rdata, q_tail, q_cnt - CW'(1)};
        if (f_cnt != '0) begin
          l_we    = 1'b1;
          l_waddr = f_tail;
          l_wdata = buf_r;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_INIT;
      init_idx  <= '0;
      op_r      <= OP_ENQ;
      qid_r     <= '0;
      buf_r     <= '0;
      q_head    <= '0;
      q_tail    <= '0;
      q_cnt     <= '0;
      rsp_valid <= 1'b0;
      rsp_addr  <= '0;
      rsp_err   <= 1'b0;
    end else begin
      rsp_valid <= 1'b0;
      case (state)
        ST_INIT: begin
          init_idx <= init_idx + AW'(1);
          if (32'(init_idx) == NUM_BUFS - 1) state <= ST_IDLE;
        end
        ST_IDLE: begin
          if (cmd_valid) begin
            op_r  <= qm_op_e'(cmd_op);
            qid_r <= cmd_qid;
            state <= ST_FETCH;
          end
        end
        ST_FETCH: begin
          q_head <= rd_head;
          q_tail <= rd_tail;
          q_cnt  <= rd_cnt;
          if ((op_r == OP_ENQ) ? (f_cnt == '0) : (rd_cnt == '0)) begin
            rsp_valid <= 1'b1;
            rsp_err   <= 1'b1;
            rsp_addr  <= '0;
            state     <= ST_IDLE;
          end else begin
            buf_r <= (op_r == OP_ENQ) ? f_head : rd_head;
            state <= ST_APPLY;
          end
        end
        default: begin
          rsp_valid <= 1'b1;
          rsp_err   <= 1'b0;
          rsp_addr  <= buf_r;
          state     <= ST_IDLE;
        end
      endcase
    end
  end

  assert_one_outstanding_R3: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_ready) |=> !cmd_ready);
  assert_rsp_pulse_R4: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid);
  assert_pool_bound_R10: assert property (@(posedge clk) disable iff (rst)
    f_cnt <= CW'(NUM_BUFS));
  assert_reject_keeps_pool_R8: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_err) |-> $stable(f_cnt));
  assert_enq_takes_one_R5: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_err && op_r == OP_ENQ) |-> f_cnt == $past(f_cnt) - CW'(1));
  assert_deq_returns_one_R10: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_err && op_r == OP_DEQ) |-> f_cnt == $past(f_cnt) + CW'(1));
endmodule

// File: tb/test_qm_buffer_manager.sv
module test_qm_buffer_manager;
  localparam int CLK_PERIOD = 10;
  localparam int NB = 16;
  localparam int NQ = 4;
  localparam int AW = $clog2(NB);
  localparam int QW = $clog2(NQ);

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cmd_valid = 1'b0;
  logic          cmd_ready;
  logic          cmd_op = 1'b0;
  logic [QW-1:0] cmd_qid = '0;
  logic          rsp_valid;
  logic [AW-1:0] rsp_addr;
  logic          rsp_err;

  int tests = 0;
  int fails = 0;
  int free_m[$];
  int vq_m[NQ][$];

  always #(CLK_PERIOD/2) clk = ~clk;

  qm_buffer_manager #(.NUM_BUFS(NB), .NUM_QUEUES(NQ)) i_qm_buffer_manager (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_qid(cmd_qid), .rsp_valid(rsp_valid),
    .rsp_addr(rsp_addr), .rsp_err(rsp_err));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Issue one command; the expected result comes from the list model
  task automatic run_cmd(input bit op, input int q, input string req);
    int  exp_addr;
    bit  exp_err;
    int  lat;
    exp_addr = 0;
    exp_err  = 1'b0;
    if (!op) begin
      if (free_m.size() == 0) exp_err = 1'b1;
      else begin
        exp_addr = free_m.pop_front();
        vq_m[q].push_back(exp_addr);
      end
    end else begin
      if (vq_m[q].size() == 0) exp_err = 1'b1;
      else begin
        exp_addr = vq_m[q].pop_front();
        free_m.push_back(exp_addr);
      end
    end
    while (!cmd_ready) @(negedge clk);
    cmd_valid = 1'b1;
    cmd_op    = op;
    cmd_qid   = QW'(q);
    @(negedge clk);
    cmd_valid = 1'b0;
    check(cmd_ready == 1'b0, "R3 busy", int'(cmd_ready), 0);
    lat = 0;
    while (!rsp_valid && lat < 8) begin
      @(negedge clk);
      lat++;
    end
    check(lat == (exp_err ? 1 : 2), "R4 latency", lat, exp_err ? 1 : 2);
    check(rsp_err == exp_err, {req, " err"}, int'(rsp_err), int'(exp_err));
    check(int'(rsp_addr) == exp_addr, {req, " addr"}, int'(rsp_addr), exp_addr);
    @(negedge clk);
    check(rsp_valid == 1'b0, "R4 pulse", int'(rsp_valid), 0);
  endtask

  task automatic t_reset_r1;
    int n;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    free_m.delete();
    for (int i = 0; i < NB; i++) free_m.push_back(i);
    for (int q = 0; q < NQ; q++) vq_m[q].delete();
    n = 0;
    while (!cmd_ready && n < 4 * NB) begin
      check(rsp_valid == 1'b0, "R1 no rsp in init", int'(rsp_valid), 0);
      @(negedge clk);
      n++;
    end
    check(n == NB, "R1 init length", n, NB);
    check(cmd_ready == 1'b1, "R1 ready", int'(cmd_ready), 1);
    run_cmd(1'b1, 0, "R1 queue empty after reset");
  endtask

  task automatic t_ascending_r2;
    for (int i = 0; i < 4; i++) run_cmd(1'b0, 1, "R2 ascending / R5");
  endtask

  task automatic t_interleave_r7;
    run_cmd(1'b0, 0, "R7");
    run_cmd(1'b0, 2, "R7");
    run_cmd(1'b0, 0, "R7");
    run_cmd(1'b0, 2, "R7");
    run_cmd(1'b1, 2, "R6 fifo");
    run_cmd(1'b1, 1, "R6 fifo");
    run_cmd(1'b1, 0, "R7 other queue");
    run_cmd(1'b1, 2, "R6 fifo");
  endtask

  task automatic t_empty_deq_r8;
    run_cmd(1'b1, 3, "R8 empty dequeue");
    run_cmd(1'b1, 3, "R8 empty dequeue again");
    run_cmd(1'b0, 3, "R8 state unchanged");
    run_cmd(1'b1, 3, "R8 state unchanged");
  endtask

  task automatic t_exhaust_r9;
    int q;
    q = 0;
    while (free_m.size() > 0) begin
      run_cmd(1'b0, q, "R5 fill");
      q = (q + 1) % NQ;
    end
    run_cmd(1'b0, 2, "R9 pool empty");
    run_cmd(1'b1, 3, "R10 refill empty pool");
    run_cmd(1'b0, 1, "R10 reuse freed");
    run_cmd(1'b1, 1, "R10");
    run_cmd(1'b1, 0, "R10");
    run_cmd(1'b1, 2, "R10");
    for (int i = 0; i < 3; i++) run_cmd(1'b0, 3, "R10 order of freed buffers");
  endtask

  task automatic t_drain_refill_r11;
    while (vq_m[2].size() > 0) run_cmd(1'b1, 2, "R11 drain");
    run_cmd(1'b1, 2, "R11 drained is empty");
    run_cmd(1'b0, 2, "R11 refill");
    run_cmd(1'b0, 2, "R11 refill");
    run_cmd(1'b1, 2, "R11 order");
    run_cmd(1'b1, 2, "R11 order");
    for (int q2 = 0; q2 < NQ; q2++)
      while (vq_m[q2].size() > 0) run_cmd(1'b1, q2, "R6 final drain");
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    t_reset_r1();
    t_ascending_r2();
    t_interleave_r7();
    t_empty_deq_r8();
    t_exhaust_r9();
    t_drain_refill_r11();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule